// File: doc/BRIEF.md
# Flash Write-In-Progress Status Generator

This block sits in the read path of a flash memory model or controller and reports the progress of an internal write (byte program, sector erase, chip erase) through the read data itself. While an internal operation runs, every read returns a status word instead of the stored byte. Bit 7 carries a data-polling indication and bit 6 flips on each successive read. Software detects completion by polling until bit 7 matches the expected value or bit 6 stops changing. When the operation finishes, reads return array data again.

An accepted start event carries the operation type and, for a program, the byte being written. A busy timer then runs for a per-type, parameterised number of clocks. The timer counts model the maximum internal write times. Command decoding and array storage stay outside the block. The array's read data enters on an input and leaves through the registered read bus.

Top module: `wr_status_gen`

## Requirements
- R1: After synchronous reset, and with reset held, `busy_o` is 0 and `rd_data_o` is 0.
- R2: A start with `op_i` = 0 (program), 1 (sector erase) or 2 (chip erase) while idle is accepted. `busy_o` is 1 from the next cycle and stays 1 for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles respectively.
- R3: A start with `op_i` = 3, or any start while `busy_o` is 1, is ignored. Busy does not begin, or its remaining length and status contents stay unchanged.
- R4: During a program, bit 7 of each read returns the inverse of bit 7 of the program data given with the start.
- R5: During a sector or chip erase, bit 7 of each read returns 0.
- R6: During busy, bit 6 of successive reads alternates, and the first busy read after an accepted start returns 1. Clock cycles without a read strobe do not advance it.
- R7: During busy, bits 5..0 of a read return `arr_data_i[5:0]`.
- R8: While idle, a read returns `arr_data_i` on all bits in `rd_data_o` one cycle after the strobe. `rd_data_o` holds its value in cycles without a read.
- R9: A read strobed in the last busy cycle returns status, and the next read returns array data. A read strobed in the same cycle as an accepted start returns array data and does not consume the first toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Internal operation start event |
| op_i | input | 2 | Operation type: 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| pdata_i | input | DATA_W | Byte being programmed (sampled with start) |
| rd_i | input | 1 | Read strobe |
| arr_data_i | input | DATA_W | Array read data |
| rd_data_o | output | DATA_W | Registered read data or status word |
| busy_o | output | 1 | Internal operation in progress |

## Verification
Two functions can fall in the same cycle: a read strobe together with the start of an operation, and a read strobe together with the expiry of the busy timer. The bench drives the read strobe and start on one negative edge to provoke the first case. It then expects array data for that read and a 1 on bit 6 for the following read. For the second case, the bench counts cycles from an accepted start so that the strobe lands on the last busy cycle. It expects the status word, then a low busy flag, then full array data on the next read.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

  // Operation type codes carried with a start event
  typedef enum logic [1:0] {
    WOP_PROG = 2'd0,
    WOP_SECT = 2'd1,
    WOP_CHIP = 2'd2,
    WOP_RSVD = 2'd3
  } wop_e;

  function automatic logic wop_valid(input logic [1:0] op);
    return op != WOP_RSVD;
  endfunction

endpackage

// File: rtl/ws_busy_timer.sv
module ws_busy_timer
  import wr_status_pkg::*;
#(
  parameter int PROG_CYC = 2000,
  parameter int SECT_CYC = 2500000,
  parameter int CHIP_CYC = 10000000,
  parameter int CNT_W    = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [1:0] op,
  output logic       busy
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (op)
      WOP_SECT: load_val = CNT_W'(SECT_CYC);
      WOP_CHIP: load_val = CNT_W'(CHIP_CYC);
      default:  load_val = CNT_W'(PROG_CYC);
    endcase
  end

  // busy stays high for exactly load_val cycles after the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (accept) begin
      cnt_q <= load_val;
      busy  <= 1'b1;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/ws_toggle.sv
module ws_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  output logic tog_next
);

  logic tog_q;

  // cleared on start so the first advance yields 1; only reads advance it
  always_ff @(posedge clk) begin
    if (rst)        tog_q <= 1'b0;
    else if (clear) tog_q <= 1'b0;
    else if (adv)   tog_q <= ~tog_q;
  end

  assign tog_next = ~tog_q;

endmodule

// File: rtl/ws_rd_path.sv
module ws_rd_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              busy,
  input  logic              poll_bit,
  input  logic              tog_bit,
  input  logic [DATA_W-1:0] arr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int POLL_POS = DATA_W - 1;
  localparam int TOG_POS  = DATA_W - 2;

  logic [DATA_W-1:0] stat_word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_POS) begin : g_poll
      assign stat_word[b] = poll_bit;
    end else if (b == TOG_POS) begin : g_tog
      assign stat_word[b] = tog_bit;
    end else begin : g_pass
      assign stat_word[b] = arr[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_data <= '0;
    else if (rd) rd_data <= busy ? stat_word : arr;
  end

endmodule

// File: rtl/wr_status_gen.sv
module wr_status_gen
  import wr_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 2000,
  parameter int SECT_CYC = 2500000,
  parameter int CHIP_CYC = 10000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);

  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic accept;
  logic poll_q;
  logic tog_next;
  logic pdata_unused;

  assign accept       = start_i && !busy_o && wop_valid(op_i);
  assign pdata_unused = ^pdata_i[DATA_W-2:0];

  // Polling bit latched at start: inverse program MSB, or 0 for erase
  always_ff @(posedge clk) begin
    if (rst)
      poll_q <= 1'b0;
    else if (accept)
      poll_q <= (op_i == WOP_PROG) ? ~pdata_i[DATA_W-1] : 1'b0;
  end

  ws_busy_timer #(
    .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC),
    .CHIP_CYC(CHIP_CYC),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .op    (op_i),
    .busy  (busy_o)
  );

  ws_toggle u_tog (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .adv     (rd_i && busy_o),
    .tog_next(tog_next)
  );

  ws_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd      (rd_i),
    .busy    (busy_o),
    .poll_bit(poll_q),
    .tog_bit (tog_next),
    .arr     (arr_data_i),
    .rd_data (rd_data_o)
  );

endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] pdata_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o
);

  logic erase_op;
  logic exp_msb;
  logic chk_unused;

  assign chk_unused = ^pdata_i[DATA_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      erase_op <= 1'b0;
      exp_msb  <= 1'b0;
    end else if (start_i && !busy_o && op_i != 2'd3) begin
      erase_op <= (op_i != 2'd0);
      exp_msb  <= ~pdata_i[DATA_W-1];
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && op_i != 2'd3) |=> busy_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !(start_i && op_i != 2'd3)) |=> !busy_o);

  // R4
  prog_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_o && !erase_op) |=> rd_data_o[DATA_W-1] == exp_msb);

  // R5
  erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_o && erase_op) |=> !rd_data_o[DATA_W-1]);

  // R7
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_o) |=> rd_data_o[DATA_W-3:0] == $past(arr_data_i[DATA_W-3:0]));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !busy_o) |=> rd_data_o == $past(arr_data_i));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));

endmodule

bind wr_status_gen ws_checker #(.DATA_W(DATA_W)) u_ws_chk (.*);

// File: tb/tb_wr_status_gen.sv
module tb_wr_status_gen;

  localparam int P_CYC = 6;
  localparam int S_CYC = 9;
  localparam int C_CYC = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [7:0] pdata_i = 8'h00;
  logic       rd_i = 1'b0;
  logic [7:0] arr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       busy_o;

  int tests = 0;
  int fails = 0;
  int bcnt  = 0;
  logic bclr = 1'b0;

  always #5 clk = ~clk;

  wr_status_gen #(
    .DATA_W(8), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .CHIP_CYC(C_CYC)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .pdata_i(pdata_i),
    .rd_i(rd_i), .arr_data_i(arr_data_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  // busy cycle counter, observed at the ports only
  always @(posedge clk) begin
    if (bclr) bcnt <= 0;
    else if (busy_o) bcnt <= bcnt + 1;
  end

  // {op, program data, array data}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'hC3, 8'h3C},
    {2'd0, 8'h12, 8'hA5},
    {2'd1, 8'hFF, 8'hFF},
    {2'd2, 8'h00, 8'h81},
    {2'd0, 8'h80, 8'h7F},
    {2'd1, 8'h55, 8'h40}
  };

  function automatic int dur(input logic [1:0] op);
    return (op == 2'd0) ? P_CYC : (op == 2'd1) ? S_CYC : C_CYC;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // tasks are entered right after a negedge and leave after the next negedge
  task automatic do_start(input logic [1:0] op, input logic [7:0] pd);
    start_i = 1'b1; op_i = op; pdata_i = pd;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a);
    rd_i = 1'b1; arr_data_i = a;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    chk(rd_data_o == 8'h00, "R1 data in reset", rd_data_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && rd_data_o == 8'h00, "R1 after release", rd_data_o, 0);

    // vector table walk: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      logic [1:0] op;
      logic [7:0] pd, ar, ex;
      logic       s7;
      {op, pd, ar} = VEC[v];
      s7 = (op == 2'd0) ? ~pd[7] : 1'b0;
      bclr = 1'b1;
      do_start(op, pd);
      bclr = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      for (int k = 0; k < 3; k++) begin
        logic [7:0] a;
        a = (k == 1) ? ~ar : ar;
        do_rd(a);
        ex = {s7, (k != 1), a[5:0]};
        chk(rd_data_o == ex, (op == 2'd0) ? "R4 R6 R7 program status" : "R5 R6 R7 erase status",
            rd_data_o, ex);
      end
      wait_idle();
      chk(bcnt == dur(op), "R2 busy length", bcnt, dur(op));
      do_rd(ar ^ 8'h0F);
      chk(rd_data_o == (ar ^ 8'h0F), "R8 idle read", rd_data_o, ar ^ 8'h0F);
      repeat (2) @(negedge clk);
      chk(rd_data_o == (ar ^ 8'h0F), "R8 hold without read", rd_data_o, ar ^ 8'h0F);
    end

    // R3 reserved op code ignored
    do_start(2'd3, 8'h00);
    chk(busy_o == 1'b0, "R3 reserved op", busy_o, 0);
    do_rd(8'h99);
    chk(rd_data_o == 8'h99, "R3 reserved op read", rd_data_o, 8'h99);

    // R3 start during busy ignored
    bclr = 1'b1;
    do_start(2'd0, 8'h00);
    bclr = 1'b0;
    @(negedge clk);
    do_start(2'd2, 8'h00);
    do_rd(8'h00);
    chk(rd_data_o == 8'hC0, "R3 status kept after ignored start", rd_data_o, 8'hC0);
    wait_idle();
    chk(bcnt == P_CYC, "R3 busy length unchanged", bcnt, P_CYC);

    // R6 idle clocks do not advance the toggle
    do_start(2'd1, 8'h00);
    do_rd(8'h00);
    chk(rd_data_o[6] == 1'b1, "R6 first toggle", rd_data_o[6], 1);
    repeat (3) @(negedge clk);
    do_rd(8'h00);
    chk(rd_data_o[6] == 1'b0, "R6 no advance on idle", rd_data_o[6], 0);
    wait_idle();

    // R9 read in the same cycle as start
    start_i = 1'b1; op_i = 2'd0; pdata_i = 8'h00; rd_i = 1'b1; arr_data_i = 8'h5A;
    @(negedge clk);
    start_i = 1'b0; rd_i = 1'b0;
    chk(rd_data_o == 8'h5A, "R9 read with start gives array", rd_data_o, 8'h5A);
    chk(busy_o == 1'b1, "R9 start with read accepted", busy_o, 1);
    do_rd(8'h00);
    chk(rd_data_o == 8'hC0, "R9 first busy read toggles to 1", rd_data_o, 8'hC0);
    wait_idle();

    // R9 read in the last busy cycle
    do_start(2'd0, 8'hFF);
    repeat (P_CYC - 1) @(negedge clk);
    chk(busy_o == 1'b1, "R9 still busy before last edge", busy_o, 1);
    do_rd(8'h2A);
    chk(rd_data_o == 8'h6A, "R9 last-cycle read gives status", rd_data_o, 8'h6A);
    chk(busy_o == 1'b0, "R9 busy dropped", busy_o, 0);
    do_rd(8'h2A);
    chk(rd_data_o == 8'h2A, "R9 next read gives array", rd_data_o, 8'h2A);

    // R1 reset in the middle of an operation
    do_start(2'd2, 8'h00);
    do_rd(8'h11);
    rst = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && rd_data_o == 8'h00, "R1 reset mid operation", rd_data_o, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule